// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block produces eight clock outputs, grouped into four sections of two, from one fast timing clock. A free-running phase counter splits each output period into `PERIOD_TICKS` ticks of the timing clock. A skew unit is `UNIT_TICKS` ticks. Each section reads two three-level select codes and picks one of nine output functions. The fine sections (one and two) offer single-unit steps from -4 to +4 units. The coarse sections (three and four) offer double-unit steps from -6 to +6 units. They also offer a halved clock, and section three adds a quartered clock while section four adds an inverted clock.

A negative skew is built as a delay of one full output period minus the skew magnitude. A new select setting waits for the start of the next zero-skew period before it takes effect. The two outputs of a section come from twin registers fed by the same signal, so they switch on the same edge. A test-mode select overrides every section and routes a reference input to all outputs.

Top module: `skew_clock_matrix`

## Requirements
- R1: While `rst` is high, every output is 0, and each section loads its active function from the select inputs present at that edge.
- R2: In every cycle, `q1[s]` equals `q0[s]` for every section `s`.
- R3: Select levels are coded 00 = LOW, 01 = MID, 10 = HIGH. Let the timing-clock edges after reset release be numbered k = 1, 2, … and let n = k-1. The output after edge k reflects phase p = n mod `PERIOD_TICKS`. For a skew of u units, the delay is d = u·`UNIT_TICKS` when u ≥ 0 and d = `PERIOD_TICKS` + u·`UNIT_TICKS` when u < 0. The output is high when ((p - d) mod `PERIOD_TICKS`) < `PERIOD_TICKS`/2.
- R4: Let idx = 3·level(f0) + level(f1), where LOW = 0, MID = 1 and HIGH = 2. Sections one and two (bits [1:0] and [3:2] of each select bus) apply u = idx - 4. Sections three and four apply u = 2·(idx - 4) for idx 1 to 7.
- R5: In section three, idx 0 (LL) gives a halved clock and idx 8 (HH) gives a quartered clock. With c = floor(n / `PERIOD_TICKS`), the halved clock is high when c is even and the quartered clock is high when c mod 4 < 2. Both keep a 50% duty cycle, and their rising edges line up with a zero-skew rising edge.
- R6: In section four, idx 0 (LL) gives the same halved clock as in section three, and idx 8 (HH) gives the zero-skew clock inverted.
- R7: The select code 11 is read as MID. A section whose two codes are both MID (or 11) outputs the zero-skew clock.
- R8: A section captures a new select setting only at the edge where the phase counter wraps from `PERIOD_TICKS`-1 to 0. A change made at any other time has no effect on the outputs until that capture.
- R9: When `test_sel` is 01, 10 or 11, every output after edge k equals `ref_in` sampled at edge k, and the section functions are bypassed. When `test_sel` is 00, the outputs follow their selected functions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst | input | 1 | Synchronous active-high reset |
| test_sel | input | 2 | Three-level test select; any code other than 00 enables bypass |
| ref_in | input | 1 | Reference routed to all outputs in test mode |
| sel_f0 | input | 8 | First select code per section, section s at bits [2s+1:2s] |
| sel_f1 | input | 8 | Second select code per section, same layout |
| q0 | output | 4 | First output of each section |
| q1 | output | 4 | Matched second output of each section |

## Verification
Two events can land on the same edge: a select change and the phase wrap that captures it and also steps the divider counter. The bench provokes this by changing selects one tick before a wrap in one scenario and well before a wrap in another. In each case the outputs must switch function exactly at phase 0, and a newly chosen divided clock must rise with the zero-skew clock. The scoreboard keeps its own phase, period count and captured codes, and judges every cycle against them. The bench also enters test mode in the middle of a period while the counters keep running, and checks that leaving test mode resumes the functions at the correct phase.

// File: rtl/skew_pkg.sv
package skew_pkg;

  localparam int NUM_SEC = 4;

  typedef enum logic [1:0] {
    SEC_FINE       = 2'd0,
    SEC_COARSE_DIV = 2'd1,
    SEC_COARSE_INV = 2'd2
  } sec_kind_e;

  typedef enum logic [1:0] {
    FN_SHIFT = 2'd0,
    FN_DIV2  = 2'd1,
    FN_DIV4  = 2'd2,
    FN_INV   = 2'd3
  } fn_e;

  typedef struct packed {
    fn_e               fn;
    logic signed [3:0] units;
  } sec_mode_t;

  // Ternary level of a two-bit code: 00 low, 10 high, 01 and 11 mid.
  function automatic int level_of(input logic [1:0] code);
    case (code)
      2'b00:   return 0;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic sec_mode_t decode_mode(input sec_kind_e kind,
                                            input logic [1:0] c0,
                                            input logic [1:0] c1);
    sec_mode_t m;
    int idx;
    idx     = 3 * level_of(c0) + level_of(c1);
    m.fn    = FN_SHIFT;
    m.units = 4'sd0;
    if (kind == SEC_FINE) begin
      m.units = 4'(idx - 4);
    end else if (idx == 0) begin
      m.fn = FN_DIV2;
    end else if (idx == 8) begin
      m.fn = (kind == SEC_COARSE_DIV) ? FN_DIV4 : FN_INV;
    end else begin
      m.units = 4'(2 * (idx - 4));
    end
    return m;
  endfunction

endpackage

// File: rtl/skew_phase_gen.sv
module skew_phase_gen #(
  parameter int PERIOD_TICKS = 32,
  parameter int PW           = $clog2(PERIOD_TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] ph,
  output logic [1:0]    cyc,
  output logic          wrap
);

  localparam logic [PW-1:0] LAST = PW'(PERIOD_TICKS - 1);

  assign wrap = (ph == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      cyc <= '0;
    end else begin
      ph <= wrap ? '0 : ph + 1'b1;
      if (wrap) cyc <= cyc + 2'd1;
    end
  end

  // R3: phase returns to zero right after its last tick
  assert_phase_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (ph == '0));

  // R5: period counter advances once per wrap
  assert_cycle_step_R5: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cyc == $past(cyc) + 2'd1));

endmodule

// File: rtl/skew_section.sv
module skew_section
  import skew_pkg::*;
#(
  parameter sec_kind_e KIND         = SEC_FINE,
  parameter int        UNIT_TICKS   = 2,
  parameter int        PERIOD_TICKS = 32,
  parameter int        PW           = $clog2(PERIOD_TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          test_on,
  input  logic          ref_in,
  input  logic [PW-1:0] ph,
  input  logic [1:0]    cyc,
  input  logic          wrap,
  input  logic [1:0]    sel0,
  input  logic [1:0]    sel1,
  output logic          q0,
  output logic          q1
);

  localparam int HALF = PERIOD_TICKS / 2;

  sec_mode_t active, decoded;
  logic      shifted_bit, fn_bit, drive;
  int        mag, delay_ticks, lagged;

  assign decoded = decode_mode(KIND, sel0, sel1);

  // Capture only at the zero-phase boundary so no runt pulse appears.
  always_ff @(posedge clk) begin
    if (rst || wrap) active <= decoded;
  end

  always_comb begin
    mag         = (active.units < 0) ? -int'(active.units) : int'(active.units);
    delay_ticks = (active.units < 0) ? PERIOD_TICKS - mag * UNIT_TICKS
                                     : mag * UNIT_TICKS;
    lagged      = int'(ph) + PERIOD_TICKS - delay_ticks;
    if (lagged >= PERIOD_TICKS) lagged = lagged - PERIOD_TICKS;
    if (lagged >= PERIOD_TICKS) lagged = lagged - PERIOD_TICKS;
    shifted_bit = (lagged < HALF);
  end

  always_comb begin
    case (active.fn)
      FN_DIV2: fn_bit = ~cyc[0];
      FN_DIV4: fn_bit = ~cyc[1];
      FN_INV:  fn_bit = ~(int'(ph) < HALF);
      default: fn_bit = shifted_bit;
    endcase
  end

  assign drive = test_on ? ref_in : fn_bit;

  // Twin output drivers fed from one net keep the pair matched.
  for (genvar i = 0; i < 2; i++) begin : g_drv
    logic r;
    always_ff @(posedge clk) begin
      if (rst) r <= 1'b0;
      else     r <= drive;
    end
  end

  assign q0 = g_drv[0].r;
  assign q1 = g_drv[1].r;

  // R8: the active function only moves at a phase wrap
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> (active == $past(active)));

  // R3: zero-skew function rises right after phase zero
  assert_zero_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (!test_on && active.fn == FN_SHIFT && active.units == 4'sd0 && ph == '0)
    |=> q0);

endmodule

// File: rtl/skew_clock_matrix.sv
module skew_clock_matrix
  import skew_pkg::*;
#(
  parameter int UNIT_TICKS       = 2,
  parameter int UNITS_PER_PERIOD = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           test_sel,
  input  logic                 ref_in,
  input  logic [2*NUM_SEC-1:0] sel_f0,
  input  logic [2*NUM_SEC-1:0] sel_f1,
  output logic [NUM_SEC-1:0]   q0,
  output logic [NUM_SEC-1:0]   q1
);

  localparam int PERIOD_TICKS = UNIT_TICKS * UNITS_PER_PERIOD;
  localparam int PW           = $clog2(PERIOD_TICKS);

  logic [PW-1:0] ph;
  logic [1:0]    cyc;
  logic          wrap;
  logic          test_on;

  assign test_on = (test_sel != 2'b00);

  skew_phase_gen #(.PERIOD_TICKS(PERIOD_TICKS), .PW(PW)) u_phase (
    .clk (clk),
    .rst (rst),
    .ph  (ph),
    .cyc (cyc),
    .wrap(wrap)
  );

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    localparam sec_kind_e K = (s < 2)  ? SEC_FINE :
                              (s == 2) ? SEC_COARSE_DIV : SEC_COARSE_INV;
    skew_section #(
      .KIND        (K),
      .UNIT_TICKS  (UNIT_TICKS),
      .PERIOD_TICKS(PERIOD_TICKS),
      .PW          (PW)
    ) u_sec (
      .clk    (clk),
      .rst    (rst),
      .test_on(test_on),
      .ref_in (ref_in),
      .ph     (ph),
      .cyc    (cyc),
      .wrap   (wrap),
      .sel0   (sel_f0[2*s +: 2]),
      .sel1   (sel_f1[2*s +: 2]),
      .q0     (q0[s]),
      .q1     (q1[s])
    );

    // R2: matched pair never differs
    assert_pair_match_R2: assert property (@(posedge clk) disable iff (rst)
      q0[s] == q1[s]);
  end

  // R9: bypass routes the reference to every output one edge later
  assert_test_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(test_on)) |-> (q0 == {NUM_SEC{$past(ref_in)}}));

  // R1: outputs are cleared by reset
  assert_reset_low_R1: assert property (@(posedge clk)
    $past(rst) |-> (q0 == '0 && q1 == '0));

endmodule

// File: tb/skew_clock_matrix_tb_top.sv
`timescale 1ns/1ps
module skew_clock_matrix_tb_top;

  localparam int UT   = 2;
  localparam int UPP  = 16;
  localparam int P    = UT * UPP;
  localparam int HALF = P / 2;
  localparam int NS   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    test_sel = 2'b00;
  logic          ref_in = 1'b0;
  logic [7:0]    f0 = 8'h55;
  logic [7:0]    f1 = 8'h55;
  logic [NS-1:0] q0, q1;

  always #2.5 clk = ~clk;

  skew_clock_matrix #(.UNIT_TICKS(UT), .UNITS_PER_PERIOD(UPP)) dut_i (
    .clk(clk), .rst(rst), .test_sel(test_sel), .ref_in(ref_in),
    .sel_f0(f0), .sel_f1(f1), .q0(q0), .q1(q1)
  );

  int            compared = 0;
  int            mismatched = 0;
  string         cur_req = "R1";
  logic [NS-1:0] exp_q[$];
  string         req_q[$];
  int            act_idx[NS];
  int            kcnt = 0;

  function automatic int lvl(input logic [1:0] c);
    return (c == 2'b00) ? 0 : ((c == 2'b10) ? 2 : 1);
  endfunction

  function automatic logic exp_bit(input int s, input int idx, input int n);
    int ph, c, u, d;
    ph = n % P;
    c  = (n / P) % 4;
    if (s >= 2 && idx == 0) return (c % 2) == 0;
    if (s == 2 && idx == 8) return c < 2;
    if (s == 3 && idx == 8) return !(ph < HALF);
    u = (s < 2) ? idx - 4 : 2 * (idx - 4);
    d = (u >= 0) ? u * UT : P + u * UT;
    return ((ph - d + P) % P) < HALF;
  endfunction

  // Driver side of the scoreboard: model pushes the expected outputs per edge.
  always @(posedge clk) begin
    logic [NS-1:0] e;
    if (rst) begin
      for (int s = 0; s < NS; s++)
        act_idx[s] = 3 * lvl(f0[2*s +: 2]) + lvl(f1[2*s +: 2]);
      kcnt = 0;
      e = '0;
    end else begin
      kcnt = kcnt + 1;
      if (test_sel != 2'b00) e = {NS{ref_in}};
      else for (int s = 0; s < NS; s++) e[s] = exp_bit(s, act_idx[s], kcnt - 1);
      if (kcnt % P == 0)
        for (int s = 0; s < NS; s++)
          act_idx[s] = 3 * lvl(f0[2*s +: 2]) + lvl(f1[2*s +: 2]);
    end
    exp_q.push_back(e);
    req_q.push_back(cur_req);
  end

  // Monitor side: pops and compares away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [NS-1:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      compared++;
      if (q0 !== e) begin
        mismatched++;
        $display("FAIL %s q0 actual=%b expected=%b t=%0t", r, q0, e, $time);
      end
      compared++;
      if (q1 !== q0) begin
        mismatched++;
        $display("FAIL R2 q1 actual=%b expected=%b t=%0t", q1, q0, $time);
      end
    end
  end

  task automatic run(input int cycles, input string r);
    cur_req = r;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state with all selects at MID
    run(3, "R1");
    rst = 1'b0;
    // R7: MID everywhere gives zero skew; R3 phase relation
    run(2 * P - 1, "R3");
    // Change lands one tick before the capturing wrap (coincident case), R8
    f0 = 8'h88; f1 = 8'h58;   // s0 LL -4, s1 HH +4, s2 LM -6, s3 HM +6
    run(P, "R8");
    run(2 * P, "R4");
    // Change well inside a period: must wait for the next wrap, R8
    run(7, "R4");
    f0 = 8'h04; f1 = 8'h0A;   // s0 LH -2, s1 MH +1, s2 LL div2, s3 LL div2
    run(P, "R8");
    run(4 * P, "R5");
    f0 = 8'hAF; f1 = 8'hA3;   // s0 11/11 MID, s1 11/00 -1, s2 HH div4, s3 HH inv
    run(P, "R8");
    run(4 * P, "R6");
    run(4 * P, "R7");
    // R9: bypass with MID then HIGH test code, entered mid-period
    run(5, "R5");
    test_sel = 2'b01;
    for (int i = 0; i < 64; i++) begin
      ref_in = ((i * 7 + 3) % 5) < 2;
      run(1, "R9");
    end
    test_sel = 2'b10;
    for (int i = 0; i < 32; i++) begin
      ref_in = (i % 3) == 0;
      run(1, "R9");
    end
    test_sel = 2'b00;
    ref_in = 1'b0;
    run(2 * P, "R9");
    run(3, "R3");
    finish_run();
  end

endmodule